// File: doc/BRIEF.md
# Fixed-Latency Token Channel Fabric with Firing Unit

This block is a small dataflow simulation fabric. It has two input channels, a unit that joins them, and one output channel. Each channel runs in one direction only and carries tokens: a data word with a presence bit. A token written into a channel cannot be read until a fixed number of cycles later. That latency is set by a parameter from 1 to 8. A channel can also start out holding a set number of tokens, loaded at reset with programmable values. Those tokens can be read from the first cycle.

The unit fires in a cycle only when three things are true: both input channels show a readable token at their head, and the output channel has room. In a firing the unit takes one token from each input and writes one token into the output, all in the same cycle. The output token is the sum of the two input words. In any other cycle the unit waits and consumes nothing. A channel raises a full flag to its writer when it holds as many tokens as its latency. A write made while the channel is full is dropped. The units talk to each other only through these channels.

The external writers drive the two input channels. An external reader takes tokens from the head of the output channel.

Top module: `tokfab_top`

## Requirements
- R1: After reset, each channel holds exactly its initial token count. Token i of a channel holds the value base+i, and all of them are readable in the first cycle after reset is released. With the defaults, channel A holds one token (0x10), channel B holds none, and the output channel holds one token (0x30).
- R2: A token accepted in cycle c is never readable before cycle c+L, where L is the latency of its channel. If no older token is ahead of it, the token is readable exactly in cycle c+L.
- R3: Each channel delivers its tokens in the order it accepted them. No token is lost or duplicated.
- R4: A channel's full flag is high exactly when it holds L tokens. A write presented while the flag is high is dropped and does not change the channel's contents.
- R5: `fire` is high in a cycle exactly when both input heads are readable and the output channel is not full. A firing removes one token from each input and writes (a + b) mod 2^W into the output channel in that same cycle.
- R6: In a cycle without a firing, no input token is consumed. A readable head token stays readable with the same value.
- R7: `o_take` removes the output head token only while `o_valid` is high. When `o_valid` is low, `o_take` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the initial tokens |
| a_wr | input | 1 | Write a token into input channel A |
| a_data | input | W | Data word for channel A |
| a_full | output | 1 | Channel A holds LAT_A tokens; writes are dropped |
| b_wr | input | 1 | Write a token into input channel B |
| b_data | input | W | Data word for channel B |
| b_full | output | 1 | Channel B holds LAT_B tokens; writes are dropped |
| o_take | input | 1 | Reader consumes the output head token |
| o_valid | output | 1 | Output channel head token is readable |
| o_data | output | W | Output channel head token data |
| fire | output | 1 | The unit fires in this cycle |

## Verification
Suppose a countdown or a pointer inside a channel goes wrong. A token then surfaces too early or too late, or out of order. This shows up in `fire` or `o_valid` in the very cycle the arrival time differs from the queue model. It reaches `o_data` once the token has passed through the output latency. A wrong occupancy count first shows as a full flag that differs from the model, in the cycle the count crosses L. Because the bench compares every output on every cycle, each fault is caught in the first cycle it reaches a port.

// File: rtl/tokfab_pkg.sv
package tokfab_pkg;
    localparam int MAX_LAT = 8;

    typedef logic [2:0] ptr_t;
    typedef logic [3:0] cnt_t;
    typedef logic [2:0] wait_t;

    function automatic ptr_t ptr_next(ptr_t p, int lat);
        return (p == ptr_t'(lat - 1)) ? ptr_t'(0) : ptr_t'(p + ptr_t'(1));
    endfunction
endpackage

// File: rtl/tokfab_channel.sv
module tokfab_channel
    import tokfab_pkg::*;
#(
    parameter int           W         = 8,
    parameter int           LAT       = 2,
    parameter int           N_INIT    = 0,
    parameter logic [W-1:0] INIT_BASE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rd_en,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    typedef struct packed {
        logic [LAT-1:0][W-1:0]  data;
        logic [LAT-1:0]         vld;
        logic [LAT-1:0][2:0]    wt;
        ptr_t                   rd_ptr;
        ptr_t                   wr_ptr;
        cnt_t                   count;
    } chan_s;

    chan_s s_q, s_d;
    logic         head_ok;
    logic [W-1:0] head_data;
    logic         is_full;
    logic         do_pop;
    logic         do_push;

    function automatic chan_s reset_state();
        chan_s s;
        s = '0;
        for (int i = 0; i < LAT; i++) begin
            if (i < N_INIT) begin
                s.data[i] = INIT_BASE + W'(i);
                s.vld[i]  = 1'b1;
            end
        end
        s.wr_ptr = ptr_t'(N_INIT % LAT);
        s.count  = cnt_t'(N_INIT);
        return s;
    endfunction

    always_comb begin
        s_d       = s_q;
        head_ok   = 1'b0;
        head_data = '0;
        for (int i = 0; i < LAT; i++) begin
            if (s_q.rd_ptr == ptr_t'(i)) begin
                head_ok   = s_q.vld[i] && (s_q.wt[i] == wait_t'(0));
                head_data = s_q.data[i];
            end
        end
        is_full = (s_q.count == cnt_t'(LAT));
        do_pop  = rd_en && head_ok;
        do_push = wr_en && !is_full;

        for (int i = 0; i < LAT; i++) begin
            if (s_q.vld[i] && (s_q.wt[i] != wait_t'(0))) begin
                s_d.wt[i] = s_q.wt[i] - wait_t'(1);
            end
            if (do_pop && (s_q.rd_ptr == ptr_t'(i))) begin
                s_d.vld[i] = 1'b0;
            end
            if (do_push && (s_q.wr_ptr == ptr_t'(i))) begin
                s_d.data[i] = wr_data;
                s_d.vld[i]  = 1'b1;
                s_d.wt[i]   = wait_t'(LAT - 1);
            end
        end

        if (do_pop) begin
            s_d.rd_ptr = ptr_next(s_q.rd_ptr, LAT);
        end
        if (do_push) begin
            s_d.wr_ptr = ptr_next(s_q.wr_ptr, LAT);
        end
        if (do_push && !do_pop) begin
            s_d.count = s_q.count + cnt_t'(1);
        end else if (do_pop && !do_push) begin
            s_d.count = s_q.count - cnt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= reset_state();
        end else begin
            s_q <= s_d;
        end
    end

    assign full     = is_full;
    assign rd_valid = head_ok;
    assign rd_data  = head_data;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= cnt_t'(LAT)); // R4
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> $stable(s_q.count)); // R4
    AST_TAKE_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_valid && !wr_en) |=> $stable(s_q.count)); // R7

    generate
        if (LAT > 1) begin : g_lat_chk
            AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
                (s_q.count == cnt_t'(0) && wr_en) |=> !rd_valid); // R2
        end
    endgenerate
endmodule

// File: rtl/tokfab_fire.sv
module tokfab_fire #(
    parameter int N_IN  = 2,
    parameter int N_OUT = 1
) (
    input  logic [N_IN-1:0]  in_ready,
    input  logic [N_OUT-1:0] out_full,
    output logic             fire
);
    always_comb begin
        fire = (&in_ready) && !(|out_full);
    end
endmodule

// File: rtl/tokfab_top.sv
module tokfab_top
    import tokfab_pkg::*;
#(
    parameter int           W      = 8,
    parameter int           LAT_A  = 3,
    parameter int           LAT_B  = 1,
    parameter int           LAT_O  = 2,
    parameter int           INIT_A = 1,
    parameter int           INIT_B = 0,
    parameter int           INIT_O = 1,
    parameter logic [W-1:0] BASE_A = 8'h10,
    parameter logic [W-1:0] BASE_B = 8'h20,
    parameter logic [W-1:0] BASE_O = 8'h30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_wr,
    input  logic [W-1:0] a_data,
    output logic         a_full,
    input  logic         b_wr,
    input  logic [W-1:0] b_data,
    output logic         b_full,
    input  logic         o_take,
    output logic         o_valid,
    output logic [W-1:0] o_data,
    output logic         fire
);
    logic         a_rdy, b_rdy, o_full;
    logic [W-1:0] a_head, b_head, sum_d;
    logic         fire_w;

    tokfab_channel #(.W(W), .LAT(LAT_A), .N_INIT(INIT_A), .INIT_BASE(BASE_A)) u_chan_a (
        .clk(clk), .rst_n(rst_n), .wr_en(a_wr), .wr_data(a_data), .full(a_full),
        .rd_en(fire_w), .rd_valid(a_rdy), .rd_data(a_head));

    tokfab_channel #(.W(W), .LAT(LAT_B), .N_INIT(INIT_B), .INIT_BASE(BASE_B)) u_chan_b (
        .clk(clk), .rst_n(rst_n), .wr_en(b_wr), .wr_data(b_data), .full(b_full),
        .rd_en(fire_w), .rd_valid(b_rdy), .rd_data(b_head));

    tokfab_fire #(.N_IN(2), .N_OUT(1)) u_fire (
        .in_ready({b_rdy, a_rdy}), .out_full(o_full), .fire(fire_w));

    always_comb begin
        sum_d = a_head + b_head;
    end

    tokfab_channel #(.W(W), .LAT(LAT_O), .N_INIT(INIT_O), .INIT_BASE(BASE_O)) u_chan_o (
        .clk(clk), .rst_n(rst_n), .wr_en(fire_w), .wr_data(sum_d), .full(o_full),
        .rd_en(o_take), .rd_valid(o_valid), .rd_data(o_data));

    assign fire = fire_w;

    AST_FIRE_ALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (a_rdy && b_rdy && !o_full)); // R5
    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && a_rdy) |=> (a_rdy && $stable(a_head))); // R6
    AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && b_rdy) |=> (b_rdy && $stable(b_head))); // R6
endmodule

// File: tb/tb_tokfab_top.sv
module tb_tokfab_top;
    localparam int W  = 8;
    localparam int LA = 3, LB = 1, LO = 2;
    localparam int IA = 1, IB = 0, IO = 1;
    localparam int BA = 'h10, BB = 'h20, BO = 'h30;
    localparam int NCYC = 240;

    typedef struct { int d; int rdy; } tok_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic a_wr = 0, b_wr = 0, o_take = 0;
    logic [W-1:0] a_data = '0, b_data = '0;
    logic a_full, b_full, o_valid, fire;
    logic [W-1:0] o_data;

    int checks = 0, errors = 0;
    bit done = 0;
    tok_t qa[$], qb[$], qo[$];

    always #10 clk = ~clk;

    tokfab_top #(.W(W), .LAT_A(LA), .LAT_B(LB), .LAT_O(LO),
                 .INIT_A(IA), .INIT_B(IB), .INIT_O(IO),
                 .BASE_A(8'(BA)), .BASE_B(8'(BB)), .BASE_O(8'(BO))) dut (
        .clk(clk), .rst_n(rst_n), .a_wr(a_wr), .a_data(a_data), .a_full(a_full),
        .b_wr(b_wr), .b_data(b_data), .b_full(b_full), .o_take(o_take),
        .o_valid(o_valid), .o_data(o_data), .fire(fire));

    task automatic chk(string req, string what, int cyc, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    task automatic drive(int cyc);
        a_data = 8'((cyc * 3) & 255);
        b_data = 8'((cyc * 5 + 7) & 255);
        if (cyc < 40)       begin a_wr = 1; b_wr = 1; o_take = 1; end
        else if (cyc < 80)  begin a_wr = 1; b_wr = 1; o_take = 0; end
        else if (cyc < 160) begin
            a_wr = 1'($urandom_range(0, 1)); b_wr = 1'($urandom_range(0, 1));
            o_take = 1'($urandom_range(0, 1));
        end
        else if (cyc < 200) begin a_wr = 0; b_wr = 0; o_take = 1; end
        else if (cyc < 220) begin a_wr = 1; b_wr = 0; o_take = 1; end
        else                begin a_wr = 0; b_wr = 1; o_take = 1; end
    endtask

    initial begin : watchdog
        #100us;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < IA; i++) qa.push_back('{BA + i, 0});
        for (int i = 0; i < IB; i++) qb.push_back('{BB + i, 0});
        for (int i = 0; i < IO; i++) qo.push_back('{BO + i, 0});
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            bit a_ok, b_ok, o_ok, af, bf, of, m_fire;
            int s;
            if (cyc > 0) @(negedge clk);
            drive(cyc);
            #2;
            a_ok = (qa.size() > 0) && (qa[0].rdy <= cyc);
            b_ok = (qb.size() > 0) && (qb[0].rdy <= cyc);
            o_ok = (qo.size() > 0) && (qo[0].rdy <= cyc);
            af = (qa.size() == LA);
            bf = (qb.size() == LB);
            of = (qo.size() == LO);
            m_fire = a_ok && b_ok && !of;
            if (cyc == 0) begin
                // R1: initial tokens present and readable at once
                chk("R1", "o_valid", cyc, int'(o_valid), 1);
                chk("R1", "o_data", cyc, int'(o_data), BO);
                chk("R1", "a_full", cyc, int'(a_full), 0);
            end
            chk("R4", "a_full", cyc, int'(a_full), int'(af));
            chk("R4", "b_full", cyc, int'(b_full), int'(bf));
            chk("R5 R6", "fire", cyc, int'(fire), int'(m_fire));
            chk("R2 R7", "o_valid", cyc, int'(o_valid), int'(o_ok));
            if (o_ok) chk("R3 R5", "o_data", cyc, int'(o_data), qo[0].d);
            s = 0;
            if (m_fire) begin
                s = (qa[0].d + qb[0].d) & 255;
                void'(qa.pop_front());
                void'(qb.pop_front());
            end
            if (o_take && o_ok) void'(qo.pop_front());
            if (m_fire) qo.push_back('{s, cyc + LO});
            if (a_wr && !af) qa.push_back('{int'(a_data), cyc + LA});
            if (b_wr && !bf) qb.push_back('{int'(b_data), cyc + LB});
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule